// File: doc/BRIEF.md
# Mailbox Interrupt Status Register

This block sits in the register space of a bus bridge and raises one interrupt request toward the host side. It holds a bank of eight 32-bit mailbox registers. A write to any mailbox sets a sticky flag belonging to that mailbox. Software clears the flag by writing a one to it.

A single 32-bit status word combines three fields. Bits 23:16 hold the eight mailbox flags, with flag n at bit 16+n. Bits 15:0 give the live level of up to sixteen incoming interrupt request lines. Bits 31:24 always read as zero.

An enable register has one bit for each of status bits 23:0. The interrupt output is a registered OR of all status bits whose enable bit is set. Any bus master may reach the registers through a plain port: one write strobe, an address and write data, and read data that is a combinational function of the address and the current state.

Top module: `mbx_irq_status`

## Requirements
- R1: After reset, every mailbox, the mailbox flags and the enable register read zero, and `irq_out` is 0.
- R2: The mailboxes sit at byte offsets 0x80 + 4·n for n = 0..7. Reading mailbox n returns the full 32-bit value most recently written to it.
- R3: A write to mailbox n sets status bit 16+n, whatever data is written. The status word is at byte offset 0x60.
- R4: Writing the status word with bit 16+n equal to 1 clears flag n. A 0 in that bit leaves flag n unchanged.
- R5: Status bits 15:0 show the current level of `irq_in`, with bit i equal to input i. Writing those bits has no effect.
- R6: Status bits 31:24 read as zero, and writing them has no effect.
- R7: The enable register is at byte offset 0x64. Bits 23:0 read back what was last written to them, and bits 31:24 read as zero.
- R8: `irq_out` is 1 on the clock cycle after a cycle in which some status bit and its enable bit are both 1. Otherwise it is 0 on that following cycle.
- R9: An address that decodes to no register reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address for the read and the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq_in | input | 16 | Incoming interrupt request levels |
| irq_out | output | 1 | Registered interrupt request toward the host |

## Verification
The assertions assume that `irq_in` and the port inputs are steady and free of unknown values at each rising edge. They also assume a single transaction per cycle, so that a mailbox write and a status clear never arrive together. The interrupt timing properties hold only in the registered-output variant, which is the default. The stimulus changes every input on the falling edge and drives only word-aligned addresses, apart from one unmapped offset. It drives a write strobe for exactly one cycle at a time, so each property always sees one well-formed transaction per edge.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
   localparam int REG_W      = 32;
   localparam int IRQ_SLOTS  = 16;
   localparam int FLAG_LSB   = 16;
   localparam int FLAG_SLOTS = 8;
   localparam int STAT_BITS  = FLAG_LSB + FLAG_SLOTS;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_ENABLE = 2'd2,
      SEL_MBX    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_irq_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int N_MBX      = 8,
   parameter int STATUS_OFS = 'h60,
   parameter int ENABLE_OFS = 'h64,
   parameter int MBX_BASE   = 'h80,
   localparam int IDX_W     = $clog2(N_MBX)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_OFS);
   localparam logic [ADDR_W-1:0] MBX_LO   = ADDR_W'(MBX_BASE);
   localparam logic [ADDR_W:0]   MBX_HI   = (ADDR_W+1)'(MBX_BASE + 4*N_MBX);

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (addr == STATUS_A) begin
         sel = SEL_STATUS;
      end else if (addr == ENABLE_A) begin
         sel = SEL_ENABLE;
      end else if ((addr >= MBX_LO) && ({1'b0, addr} < MBX_HI) && (addr[1:0] == 2'b00)) begin
         sel = SEL_MBX;
         idx = IDX_W'((addr - MBX_LO) >> 2);
      end
   end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
   parameter int N_MBX    = 8,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = $clog2(N_MBX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_word,
   output logic [N_MBX-1:0]  wr_pulse
);
   logic [DATA_W-1:0] box_q [N_MBX];

   for (genvar k = 0; k < N_MBX; k++) begin : g_box
      assign wr_pulse[k] = wr_hit && (idx == IDX_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            box_q[k] <= '0;
         end else if (wr_pulse[k]) begin
            box_q[k] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < N_MBX; k++) begin
         if (idx == IDX_W'(k)) rd_word = box_q[k];
      end
   end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
   parameter int N_MBX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MBX-1:0] set_vec,
   input  logic [N_MBX-1:0] clr_vec,
   output logic [N_MBX-1:0] flags
);
   // A set in the same cycle as a clear leaves the flag at 1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flags & ~clr_vec) | set_vec;
      end
   end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int W       = 24,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] enable,
   output logic         irq
);
   logic any_hit;
   assign any_hit = |(status & enable);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_hit;
      end
   end else begin : g_comb
      assign irq = any_hit;
   end
endmodule

// File: rtl/mbx_irq_status.sv
module mbx_irq_status
   import mbx_irq_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int N_MBX      = 8,
   parameter int N_IRQ      = 16,
   parameter int STATUS_OFS = 'h60,
   parameter int ENABLE_OFS = 'h64,
   parameter int MBX_BASE   = 'h80,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [N_IRQ-1:0]  irq_in,
   output logic              irq_out
);
   localparam int IDX_W = $clog2(N_MBX);

   if (N_IRQ < 1 || N_IRQ > IRQ_SLOTS) begin : g_bad_irq
      $error("N_IRQ must lie in 1..16");
   end
   if (N_MBX < 2 || N_MBX > FLAG_SLOTS) begin : g_bad_mbx
      $error("N_MBX must lie in 2..8");
   end
   if ((STATUS_OFS % 4) != 0 || (ENABLE_OFS % 4) != 0 || (MBX_BASE % 4) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (MBX_BASE + 4*N_MBX > (1 << ADDR_W)) begin : g_bad_range
      $error("mailbox range exceeds address space");
   end
   if ((STATUS_OFS >= MBX_BASE && STATUS_OFS < MBX_BASE + 4*N_MBX) ||
       (ENABLE_OFS >= MBX_BASE && ENABLE_OFS < MBX_BASE + 4*N_MBX) ||
       (STATUS_OFS == ENABLE_OFS)) begin : g_bad_overlap
      $error("register offsets overlap");
   end

   reg_sel_e            sel;
   logic [IDX_W-1:0]    idx;
   logic [REG_W-1:0]    mbx_rd;
   logic [N_MBX-1:0]    mbx_wr;
   logic [N_MBX-1:0]    clr_vec;
   logic [N_MBX-1:0]    flags_q;
   logic [STAT_BITS-1:0] en_q;
   logic [STAT_BITS-1:0] status_w;

   mbx_decode #(
      .ADDR_W(ADDR_W), .N_MBX(N_MBX), .STATUS_OFS(STATUS_OFS),
      .ENABLE_OFS(ENABLE_OFS), .MBX_BASE(MBX_BASE)
   ) u_decode (
      .addr(addr), .sel(sel), .idx(idx)
   );

   mbx_bank #(.N_MBX(N_MBX), .DATA_W(REG_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (sel == SEL_MBX)), .idx(idx),
      .wr_data(wr_data), .rd_word(mbx_rd), .wr_pulse(mbx_wr)
   );

   assign clr_vec = (wr_en && (sel == SEL_STATUS)) ? wr_data[FLAG_LSB +: N_MBX] : '0;

   mbx_flags #(.N_MBX(N_MBX)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_vec(mbx_wr), .clr_vec(clr_vec), .flags(flags_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en && (sel == SEL_ENABLE)) begin
         en_q <= wr_data[STAT_BITS-1:0];
      end
   end

   always_comb begin
      status_w = '0;
      status_w[FLAG_LSB +: N_MBX] = flags_q;
      status_w[N_IRQ-1:0]         = irq_in;
   end

   irq_merge #(.W(STAT_BITS), .REG_OUT(REG_OUT)) u_merge (
      .clk(clk), .rst_n(rst_n), .status(status_w), .enable(en_q), .irq(irq_out)
   );

   always_comb begin
      unique case (sel)
         SEL_STATUS: rd_data = REG_W'(status_w);
         SEL_ENABLE: rd_data = REG_W'(en_q);
         SEL_MBX:    rd_data = mbx_rd;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/mbx_irq_status_chk.sv
module mbx_irq_status_chk #(
   parameter int ADDR_W     = 8,
   parameter int N_MBX      = 8,
   parameter int N_IRQ      = 16,
   parameter int STATUS_OFS = 'h60,
   parameter int MBX_BASE   = 'h80,
   parameter bit REG_OUT    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wr_data,
   input logic [31:0]       rd_data,
   input logic [N_IRQ-1:0]  irq_in,
   input logic              irq_out,
   input logic [N_MBX-1:0]  flags,
   input logic [23:0]       enable,
   input logic [23:0]       status
);
   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

   for (genvar k = 0; k < N_MBX; k++) begin : g_flag
      // R3: writing mailbox k leaves flag k set on the next cycle
      assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(MBX_BASE + 4*k)) |=> flags[k])
         else $error("flag %0d not set after mailbox write", k);

      // R4: a flag only drops after a one was written to its status bit
      assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags[k]) |-> $past(wr_en && addr == STATUS_A && wr_data[16+k]))
         else $error("flag %0d cleared without a write of one", k);
   end

   // R5: status low bits mirror the request inputs
   assert_irq_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == STATUS_A) |-> (rd_data[N_IRQ-1:0] == irq_in))
      else $error("status low bits differ from irq_in");

   // R6: reserved top byte of the status word reads zero
   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == STATUS_A) |-> (rd_data[31:24] == 8'h00))
      else $error("reserved status bits nonzero");

   if (REG_OUT) begin : g_out
      // R8: enabled status raises the output one cycle later
      assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (|(status & enable)) |=> irq_out)
         else $error("irq_out missing");

      // R8: no enabled status keeps the output low one cycle later
      assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(status & enable)) |=> !irq_out)
         else $error("irq_out spurious");
   end
endmodule

bind mbx_irq_status mbx_irq_status_chk #(
   .ADDR_W(ADDR_W), .N_MBX(N_MBX), .N_IRQ(N_IRQ),
   .STATUS_OFS(STATUS_OFS), .MBX_BASE(MBX_BASE), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out),
   .flags(flags_q), .enable(en_q), .status(status_w)
);

// File: tb/test_mbx_irq_status.sv
`timescale 1ns/1ps
module test_mbx_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [15:0] irq_in = '0;
   logic        irq_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbx_irq_status i_mbx_irq_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [15:0] irq;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 32'h0,          8'h60, 16'h0000, 32'h0000_0000, 4'd1}, // R1 status
      '{1'b0, 8'h00, 32'h0,          8'h64, 16'h0000, 32'h0000_0000, 4'd1}, // R1 enable
      '{1'b0, 8'h00, 32'h0,          8'h80, 16'h0000, 32'h0000_0000, 4'd1}, // R1 mailbox
      '{1'b1, 8'h88, 32'hA5A5_0001,  8'h88, 16'h0000, 32'hA5A5_0001, 4'd2}, // R2 mbx2
      '{1'b0, 8'h00, 32'h0,          8'h60, 16'h0000, 32'h0004_0000, 4'd3}, // R3 flag2
      '{1'b1, 8'h9C, 32'hDEAD_BEEF,  8'h60, 16'h8001, 32'h0084_8001, 4'd3}, // R3 flag7
      '{1'b1, 8'h60, 32'h0000_0000,  8'h60, 16'h0000, 32'h0084_0000, 4'd4}, // R4 zeros keep
      '{1'b1, 8'h60, 32'h0004_FFFF,  8'h60, 16'h1234, 32'h0080_1234, 4'd5}, // R4/R5 clear2, low ignored
      '{1'b1, 8'h60, 32'hFF00_0000,  8'h60, 16'h0000, 32'h0080_0000, 4'd6}, // R6 reserved ignored
      '{1'b1, 8'h64, 32'hFFFF_FFFF,  8'h64, 16'h0000, 32'h00FF_FFFF, 4'd7}, // R7 enable
      '{1'b1, 8'h40, 32'h1234_5678,  8'h40, 16'h0000, 32'h0000_0000, 4'd9}, // R9 unmapped
      '{1'b0, 8'h00, 32'h0,          8'h9C, 16'h0000, 32'hDEAD_BEEF, 4'd2}, // R2 mbx7 held
      '{1'b1, 8'h9C, 32'h0000_0001,  8'h9C, 16'h0000, 32'h0000_0001, 4'd2}, // R2 overwrite
      '{1'b1, 8'h60, 32'h0080_0000,  8'h60, 16'h0000, 32'h0000_0000, 4'd4}  // R4 clear7
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check({31'b0, irq_out}, 32'h0, "R1 irq_out");

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         irq_in = VEC[v].irq;
         if (VEC[v].wr) begin
            addr = VEC[v].waddr; wr_data = VEC[v].wdata; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
         end
         addr = VEC[v].raddr;
         #1;
         check(rd_data, VEC[v].exp, $sformatf("R%0d vector %0d", VEC[v].req, v));
      end

      // R8: live input with enable set raises irq_out after one edge
      @(negedge clk); irq_in = 16'h0008;
      @(posedge clk); #1;
      check({31'b0, irq_out}, 32'h1, "R8 raise on input");
      @(negedge clk); irq_in = 16'h0000;
      @(posedge clk); #1;
      check({31'b0, irq_out}, 32'h0, "R8 drop on input");

      // R8: mask leaves only flag0 enabled
      write_reg(8'h64, 32'h0001_0000);
      @(negedge clk); irq_in = 16'hFFFF;
      @(posedge clk); #1;
      check({31'b0, irq_out}, 32'h0, "R8 masked inputs");

      // R3/R8: mailbox 0 write, output follows one cycle after the flag
      @(negedge clk); addr = 8'h80; wr_data = 32'h7; wr_en = 1'b1;
      @(posedge clk); #1; wr_en = 1'b0;
      check({31'b0, irq_out}, 32'h0, "R8 not yet");
      @(posedge clk); #1;
      check({31'b0, irq_out}, 32'h1, "R8 after flag0");

      // R4/R8: clear flag0, output drops one cycle later
      @(negedge clk); addr = 8'h60; wr_data = 32'h0001_0000; wr_en = 1'b1;
      @(posedge clk); #1; wr_en = 1'b0;
      check({31'b0, irq_out}, 32'h1, "R8 still high");
      check(rd_data, 32'h0000_FFFF, "R4 flag0 cleared");
      @(posedge clk); #1;
      check({31'b0, irq_out}, 32'h0, "R8 dropped");

      // R1: reset during operation
      write_reg(8'h84, 32'h5555_AAAA);
      @(negedge clk); irq_in = 16'h0000; rst_n = 1'b0;
      #1;
      check({31'b0, irq_out}, 32'h0, "R1 irq_out in reset");
      addr = 8'h60; #1; check(rd_data, 32'h0, "R1 status after reset");
      addr = 8'h64; #1; check(rd_data, 32'h0, "R1 enable after reset");
      addr = 8'h88; #1; check(rd_data, 32'h0, "R1 mailbox after reset");
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule